// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a prescaled VCO clock by a programmable 16-bit integer N. A small fractional accumulator adds a 3-bit increment NF once per divider cycle and wraps at a selectable modulus Q of 8 or 5. Each wrap lengthens the following division by one clock. The long-run division ratio is therefore N + NF/Q.

At the end of every divider cycle the block gives one pulse to the main phase comparator. It exports the updated accumulator value as the amplitude code for the fractional compensation current, and it raises a compensation timing window that lasts a fixed number of input clocks.

New ratio settings are written through a single load strobe into holding registers. They take over only at a divider-cycle boundary, so a cycle that is already running is never cut short or stretched. While the power enable is low the divider stays in a known starting state. When the enable returns, the first cycle is a full, clean cycle.

Top module: `fracn_main_div`

## Requirements
- R1: While `rst` is high at a clock edge, `div_pulse`, `comp_win` and `acc_val` are 0 after that edge, and the ratio returns to the parameter defaults (N = 1000, NF = 0, modulus 8). The first pulse after reset is released comes exactly DEF_N clocks after the first enabled edge.
- R2: With NF = 0, `div_pulse` is high for exactly one clock and repeats every N clocks.
- R3: At every pulse the accumulator becomes (acc + NF) mod Q. The cycle that follows lasts N + floor((acc + NF)/Q) clocks, which can add up to two clocks when NF ≥ Q. Over any Q consecutive cycles the total is N·Q + NF clocks.
- R4: `ld_mod5` = 0 selects modulus 8 and `ld_mod5` = 1 selects modulus 5. `acc_val` always stays below the active modulus.
- R5: `acc_val` takes its new value in the same clock in which `div_pulse` is high, and holds that value until the next pulse.
- R6: `comp_win` goes high in the clock of each pulse and stays high for exactly 128 clocks.
- R7: A load strobe captures `ld_n`, `ld_nf` and `ld_mod5`. The cycle in progress finishes with its old length. At the next boundary the new values take over, the accumulator is cleared to 0, and the next cycle lasts exactly the new N.
- R8: A loaded N below 512 is raised to 512.
- R9: While `pwr_en` is low there are no pulses, and `comp_win` and `acc_val` are 0. A pending load takes effect during this time. The first pulse after `pwr_en` rises comes exactly N clocks after the first enabled edge, with the accumulator starting from 0.
- R10: A load strobe sampled at the same edge as a boundary does not affect the cycle that starts there. It takes over at the boundary after that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled VCO clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Divider enabled when high; held in start state when low |
| ld_stb | input | 1 | One-clock strobe that captures the ratio inputs |
| ld_n | input | 16 | Integer divide value N |
| ld_nf | input | 3 | Fractional increment NF |
| ld_mod5 | input | 1 | Modulus select: 0 gives 8, 1 gives 5 |
| div_pulse | output | 1 | One-clock pulse at the end of each divider cycle |
| acc_val | output | 3 | Fractional accumulator value (compensation amplitude code) |
| comp_win | output | 1 | Compensation timing window, 128 clocks long |

## Verification
The hardest case to reach from the ports is a load strobe that lands exactly on the edge where the divider reaches its terminal count. The bench reaches it by first settling on a known plain integer N. It then counts N falling edges after an observed pulse and raises the strobe on the last of those, so the strobe is sampled exactly at the boundary edge. A behavioural reference model is compared on every clock. Separate period measurements over whole moduli confirm the N·Q + NF total, including increments larger than the modulus.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int unsigned NW = 16;          // integer divide width
  localparam int unsigned FW = 3;           // fractional increment width
  localparam int unsigned QA = 8;           // modulus when select = 0
  localparam int unsigned QB = 5;           // modulus when select = 1
  localparam int unsigned QMAX = (QA > QB) ? QA : QB;
  localparam int unsigned QMIN = (QA < QB) ? QA : QB;
  localparam int unsigned AW = $clog2(QMAX);
  localparam int unsigned SW = ((AW > FW) ? AW : FW) + 1;
  localparam int unsigned MAX_SUM = (QMAX - 1) + (2**FW - 1);
  localparam int unsigned XW = $clog2(MAX_SUM / QMIN + 1);

  typedef struct packed {
    logic [NW-1:0] n;
    logic [FW-1:0] nf;
    logic          sel_b;
  } ratio_t;
endpackage

// File: rtl/fnd_ratio_regs.sv
module fnd_ratio_regs
  import fnd_pkg::*;
#(
  parameter int unsigned DEF_N   = 1000,
  parameter int unsigned DEF_NF  = 0,
  parameter bit          DEF_SEL = 1'b0,
  parameter int unsigned N_MIN   = 512
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   tc,
  input  logic   ld_stb,
  input  ratio_t ld_val,
  output ratio_t work_q,
  output ratio_t work_nx,
  output logic   apply
);
  localparam ratio_t DEF_R = '{n: NW'(DEF_N), nf: FW'(DEF_NF), sel_b: DEF_SEL};

  ratio_t shadow_q;
  ratio_t ld_clamped;
  logic   pend_q;

  always_comb begin
    ld_clamped = ld_val;
    if (ld_val.n < NW'(N_MIN)) ld_clamped.n = NW'(N_MIN);
  end

  assign apply   = pend_q && (tc || !en);
  assign work_nx = apply ? shadow_q : work_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= DEF_R;
      work_q   <= DEF_R;
      pend_q   <= 1'b0;
    end else begin
      if (apply) work_q <= shadow_q;
      if (ld_stb) begin
        shadow_q <= ld_clamped;
        pend_q   <= 1'b1;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> pend_q);  // R7
  AST_N_FLOOR: assert property (@(posedge clk) disable iff (rst)
    work_q.n >= NW'(N_MIN));  // R8
endmodule

// File: rtl/fnd_accum.sv
module fnd_accum
  import fnd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tc,
  input  logic          apply,
  input  logic [FW-1:0] nf,
  input  logic          sel_b,
  output logic [AW-1:0] acc_q,
  output logic [XW-1:0] extra
);
  logic [SW-1:0] sum;
  logic [SW-1:0] qv;
  logic [SW-1:0] wraps;
  logic [SW-1:0] acc_nx;

  assign sum    = SW'(acc_q) + SW'(nf);
  assign qv     = sel_b ? SW'(QB) : SW'(QA);
  assign wraps  = sel_b ? (sum / SW'(QB)) : (sum / SW'(QA));
  assign acc_nx = sum - wraps * qv;
  assign extra  = XW'(wraps);

  always_ff @(posedge clk) begin
    if (rst || !en) acc_q <= '0;
    else if (tc)    acc_q <= apply ? '0 : acc_nx[AW-1:0];
  end

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
    SW'(acc_q) < qv);  // R4
endmodule

// File: rtl/fnd_count.sv
module fnd_count
  import fnd_pkg::*;
#(
  parameter int unsigned DEF_N = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [NW-1:0] n_next,
  input  logic [XW-1:0] extra,
  output logic          tc,
  output logic          div_pulse
);
  localparam int unsigned CW = NW + 1;

  logic [CW-1:0] cnt_q;

  assign tc = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CW'(DEF_N - 1);
      div_pulse <= 1'b0;
    end else if (!en) begin
      cnt_q     <= CW'(n_next) - CW'(1);
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= tc;
      if (tc) cnt_q <= CW'(n_next) + CW'(extra) - CW'(1);
      else    cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);  // R2
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !div_pulse);  // R9
endmodule

// File: rtl/fnd_window.sv
module fnd_window #(
  parameter int unsigned WIN_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tc,
  output logic comp_win
);
  localparam int unsigned LW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      left_q   <= '0;
      comp_win <= 1'b0;
    end else if (tc) begin
      left_q   <= LW'(WIN_LEN - 1);
      comp_win <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - LW'(1);
    end else begin
      comp_win <= 1'b0;
    end
  end

  AST_WIN_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !comp_win);  // R9
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fnd_pkg::*;
#(
  parameter int unsigned DEF_N   = 1000,
  parameter int unsigned DEF_NF  = 0,
  parameter bit          DEF_SEL = 1'b0,
  parameter int unsigned N_MIN   = 512,
  parameter int unsigned WIN_LEN = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_en,
  input  logic          ld_stb,
  input  logic [NW-1:0] ld_n,
  input  logic [FW-1:0] ld_nf,
  input  logic          ld_mod5,
  output logic          div_pulse,
  output logic [AW-1:0] acc_val,
  output logic          comp_win
);
  ratio_t        ld_val;
  ratio_t        work_q;
  ratio_t        work_nx;
  logic          apply;
  logic          tc;
  logic [XW-1:0] extra;
  logic [XW-1:0] extra_g;

  assign ld_val  = '{n: ld_n, nf: ld_nf, sel_b: ld_mod5};
  assign extra_g = apply ? '0 : extra;

  fnd_ratio_regs #(
    .DEF_N(DEF_N), .DEF_NF(DEF_NF), .DEF_SEL(DEF_SEL), .N_MIN(N_MIN)
  ) u_regs (
    .clk(clk), .rst(rst), .en(pwr_en), .tc(tc), .ld_stb(ld_stb),
    .ld_val(ld_val), .work_q(work_q), .work_nx(work_nx), .apply(apply)
  );

  fnd_accum u_acc (
    .clk(clk), .rst(rst), .en(pwr_en), .tc(tc), .apply(apply),
    .nf(work_q.nf), .sel_b(work_q.sel_b), .acc_q(acc_val), .extra(extra)
  );

  fnd_count #(.DEF_N(DEF_N)) u_cnt (
    .clk(clk), .rst(rst), .en(pwr_en), .n_next(work_nx.n),
    .extra(extra_g), .tc(tc), .div_pulse(div_pulse)
  );

  fnd_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .en(pwr_en), .tc(tc), .comp_win(comp_win)
  );

  AST_WIN_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> comp_win);  // R6
  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && $past(pwr_en) && !div_pulse) |-> $stable(acc_val));  // R5
endmodule

// File: tb/tb_fracn_main_div.sv
module tb_fracn_main_div;
  localparam int DEF_N = 1000;
  localparam int WIN   = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_en = 1'b1;
  logic        ld_stb = 1'b0;
  logic [15:0] ld_n = 16'd0;
  logic [2:0]  ld_nf = 3'd0;
  logic        ld_mod5 = 1'b0;
  logic        div_pulse;
  logic [2:0]  acc_val;
  logic        comp_win;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fracn_main_div dut (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .ld_stb(ld_stb), .ld_n(ld_n),
    .ld_nf(ld_nf), .ld_mod5(ld_mod5), .div_pulse(div_pulse),
    .acc_val(acc_val), .comp_win(comp_win)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_n = DEF_N, m_nf = 0, m_q = 8;
  int s_n = DEF_N, s_nf = 0, s_q = 8;
  int m_pend = 0, m_el = 0, m_len = DEF_N, m_acc = 0, m_w = 0, m_pul = 0;

  always @(posedge clk) begin
    bit r, e, s;
    int ln, lnf, lq, sum;
    r = rst; e = pwr_en; s = ld_stb;
    ln = ld_n; lnf = ld_nf; lq = ld_mod5 ? 5 : 8;
    #1;
    if (r) begin
      m_n = DEF_N; m_nf = 0; m_q = 8; s_n = DEF_N; s_nf = 0; s_q = 8;
      m_pend = 0; m_el = 0; m_len = DEF_N; m_acc = 0; m_w = 0; m_pul = 0;
    end else begin
      if (!e) begin
        if (m_pend != 0) begin m_n = s_n; m_nf = s_nf; m_q = s_q; m_pend = 0; end
        m_acc = 0; m_el = 0; m_len = m_n; m_w = 0; m_pul = 0;
      end else begin
        m_el++; m_pul = 0;
        if (m_w > 0) m_w--;
        if (m_el == m_len) begin
          m_pul = 1; m_w = WIN; m_el = 0;
          if (m_pend != 0) begin
            m_n = s_n; m_nf = s_nf; m_q = s_q; m_pend = 0; m_acc = 0; m_len = m_n;
          end else begin
            sum = m_acc + m_nf;
            m_len = m_n + sum / m_q;
            m_acc = sum % m_q;
          end
        end
      end
      if (s) begin
        s_n = (ln < 512) ? 512 : ln; s_nf = lnf; s_q = lq; m_pend = 1;
      end
    end
    if (!done) begin
      check(div_pulse == m_pul, "R2 R3 R7 R9 R10 pulse", div_pulse, m_pul);
      check(acc_val == m_acc, "R3 R4 R5 acc", acc_val, m_acc);
      check(comp_win == (m_w > 0), "R6 window", comp_win, (m_w > 0));
    end
  end

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic wait_pulse();
    do edge1(); while (!div_pulse);
  endtask

  task automatic load(input int n, input int nf, input bit m5);
    @(negedge clk);
    ld_n = 16'(n); ld_nf = 3'(nf); ld_mod5 = m5; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic clocks_to_pulse(output int c);
    c = 0;
    do begin edge1(); c++; end while (!div_pulse);
  endtask

  task automatic measure(input int k, output int c);
    int t;
    c = 0;
    wait_pulse();
    for (int i = 0; i < k; i++) begin
      clocks_to_pulse(t);
      c += t;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int c, bad;
    repeat (3) @(negedge clk);
    check(div_pulse == 0, "R1 reset pulse", div_pulse, 0);
    check(comp_win == 0, "R1 reset window", comp_win, 0);
    check(acc_val == 0, "R1 reset acc", acc_val, 0);
    rst = 1'b0;
    clocks_to_pulse(c);
    check(c == DEF_N, "R1 default period", c, DEF_N);

    // R2 plain integer period
    load(520, 0, 0);
    wait_pulse();
    measure(1, c);
    check(c == 520, "R2 integer period", c, 520);

    // R5 accumulator sequence and R3 total over modulus 8
    load(530, 3, 0);
    wait_pulse();
    check(acc_val == 0, "R7 acc cleared at apply", acc_val, 0);
    for (int k = 1; k <= 8; k++) begin
      wait_pulse();
      check(acc_val == (3 * k) % 8, "R5 acc at pulse", acc_val, (3 * k) % 8);
    end
    measure(8, c);
    check(c == 8 * 530 + 3, "R3 modulus 8 total", c, 8 * 530 + 3);

    // R4 modulus 5
    load(540, 2, 1);
    wait_pulse();
    measure(5, c);
    check(c == 5 * 540 + 2, "R4 modulus 5 total", c, 5 * 540 + 2);

    // R3 increment above modulus
    load(512, 7, 1);
    wait_pulse();
    measure(5, c);
    check(c == 5 * 512 + 7, "R3 NF above modulus total", c, 5 * 512 + 7);
    load(515, 7, 0);
    wait_pulse();
    measure(8, c);
    check(c == 8 * 515 + 7, "R4 modulus 8 NF 7 total", c, 8 * 515 + 7);

    // R6 window length
    wait_pulse();
    c = 0;
    while (comp_win) begin c++; edge1(); end
    check(c == WIN, "R6 window width", c, WIN);

    // R8 clamp
    load(100, 0, 0);
    wait_pulse();
    measure(1, c);
    check(c == 512, "R8 clamp to 512", c, 512);

    // R10 strobe on the boundary edge
    wait_pulse();
    repeat (511) @(negedge clk);
    load(600, 0, 0);
    check(div_pulse == 1, "R10 strobe aligned to boundary", div_pulse, 1);
    clocks_to_pulse(c);
    check(c == 512, "R10 cycle after aligned strobe", c, 512);
    clocks_to_pulse(c);
    check(c == 600, "R10 following cycle uses new N", c, 600);

    // R7 load in mid-cycle
    c = 0;
    repeat (100) begin edge1(); c++; end
    ld_n = 16'd700; ld_nf = 3'd0; ld_mod5 = 1'b0; ld_stb = 1'b1;
    edge1(); c++;
    ld_stb = 1'b0;
    while (!div_pulse) begin edge1(); c++; end
    check(c == 600, "R7 running cycle keeps old N", c, 600);
    clocks_to_pulse(c);
    check(c == 700, "R7 new N after boundary", c, 700);

    // R9 power-down
    @(negedge clk);
    pwr_en = 1'b0;
    bad = 0;
    load(515, 1, 1);
    repeat (300) begin
      edge1();
      if (div_pulse || comp_win || acc_val != 0) bad++;
    end
    check(bad == 0, "R9 quiet while off", bad, 0);
    @(negedge clk);
    pwr_en = 1'b1;
    clocks_to_pulse(c);
    check(c == 515, "R9 first period after enable", c, 515);
    measure(5, c);
    check(c == 5 * 515 + 1, "R9 fractional after enable", c, 5 * 515 + 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule